// File: doc/BRIEF.md
# Bidirectional Logical Shifter

This block moves an N-bit word left or right by a variable number of positions in a single combinational pass. Positions that the data leaves behind are filled with zeros. A one-bit direction input picks the direction. Because only zeros enter, a left shift multiplies an unsigned word by a power of two, modulo 2^N. A right shift divides the word by a power of two and discards the remainder.

The datapath is a chain of log2(N) stages. Stage i handles shift-amount bit i. When that bit is clear, the stage forwards its word as it is. When the bit is set, the stage moves the word by 2^i places. Every bit of a stage has a three-way selector that picks one of three values: the bit in the same position, the bit 2^i places below, or the bit 2^i places above. A source position outside the word supplies a zero. A small decode turns the stage's amount bit and the direction into the selector code. Both directions therefore share a single chain, and the block needs no separate left and right networks. The block has no clock and no state, so its output follows its inputs after the logic delay.

Top module: `bidir_log_shifter`

## Requirements
- R1: When `shamt` is 0, `data_out` equals `data_in` for either value of `dir_left`.
- R2: When `dir_left` is 1, `data_out` equals (`data_in` · 2^`shamt`) mod 2^N, and the low `shamt` bits are zero.
- R3: When `dir_left` is 0, `data_out` equals floor(`data_in` / 2^`shamt`), and the high `shamt` bits are zero.
- R4: At the largest amount, N−1, a left shift leaves only `data_in[0]` and places it in bit N−1. A right shift at that amount leaves only `data_in[N-1]` and places it in bit 0.
- R5: The number of 1 bits in `data_out` never exceeds the number of 1 bits in `data_in`.
- R6: When `data_in` has exactly one bit set at position p, `data_out` has that bit at p+`shamt` for a left shift, or at p−`shamt` for a right shift. When that position falls outside [0, N−1], `data_out` is zero.
- R7: The shift-amount width is $clog2(N), and N must be a power of two. At N = 4, input 0010 shifted by 2 gives 1000 to the left and 0000 to the right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | N | Word to be shifted |
| shamt | input | $clog2(N) | Number of positions to shift |
| dir_left | input | 1 | 1 selects a left shift, 0 selects a right shift |
| data_out | output | N | Shifted word with zero fill |

## Verification
Some properties hold for every input, and the bound checker tests these whenever the inputs settle. They are: pass-through at a zero amount, zeros in the vacated low bits after a left shift, zeros in the vacated high bits after a right shift, no growth in the count of set bits, and a single set bit staying single or disappearing. These checks do not establish that the surviving bits arrive at exactly the right positions. The bench's arithmetic comparison shows that across every word, amount and direction at N = 8. A separate four-bit instance shows the small-width case.

// File: rtl/bls_pkg.sv
package bls_pkg;

  // Per-bit source choice inside one stage
  typedef enum logic [1:0] {
    SEL_PASS = 2'b00,  // keep the bit in the same position
    SEL_LOW  = 2'b01,  // take the bit 2^i places lower (left move)
    SEL_HIGH = 2'b10   // take the bit 2^i places higher (right move)
  } bls_sel_e;

endpackage

// File: rtl/bls_decode.sv
module bls_decode
  import bls_pkg::*;
(
  input  logic     stage_en,
  input  logic     dir_left,
  output bls_sel_e sel
);

  // Two gates' worth of decode: enable gates the direction
  always_comb begin
    if (!stage_en)      sel = SEL_PASS;
    else if (dir_left)  sel = SEL_LOW;
    else                sel = SEL_HIGH;
  end

endmodule

// File: rtl/bls_mux3.sv
module bls_mux3
  import bls_pkg::*;
(
  input  bls_sel_e sel,
  input  logic     src_same,
  input  logic     src_low,
  input  logic     src_high,
  output logic     q
);

  always_comb begin
    unique case (sel)
      SEL_PASS: q = src_same;
      SEL_LOW:  q = src_low;
      SEL_HIGH: q = src_high;
      default:  q = 1'b0;
    endcase
  end

endmodule

// File: rtl/bls_stage.sv
module bls_stage
  import bls_pkg::*;
#(
  parameter int N    = 8,
  parameter int DIST = 1
) (
  input  logic [N-1:0] d_in,
  input  logic         stage_en,
  input  logic         dir_left,
  output logic [N-1:0] d_out
);

  bls_sel_e sel;

  bls_decode u_dec (
    .stage_en (stage_en),
    .dir_left (dir_left),
    .sel      (sel)
  );

  for (genvar j = 0; j < N; j++) begin : g_bit
    logic from_low;
    logic from_high;

    if (j >= DIST) begin : g_lo_in
      assign from_low = d_in[j-DIST];
    end else begin : g_lo_zero
      assign from_low = 1'b0;
    end

    if (j + DIST < N) begin : g_hi_in
      assign from_high = d_in[j+DIST];
    end else begin : g_hi_zero
      assign from_high = 1'b0;
    end

    bls_mux3 u_mux (
      .sel      (sel),
      .src_same (d_in[j]),
      .src_low  (from_low),
      .src_high (from_high),
      .q        (d_out[j])
    );
  end

endmodule

// File: rtl/bidir_log_shifter.sv
module bidir_log_shifter #(
  parameter  int N = 8,
  localparam int K = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] data_in,
  input  logic [K-1:0] shamt,
  input  logic         dir_left,
  output logic [N-1:0] data_out
);

  localparam bit WIDTH_OK = (N >= 2) && ((1 << K) == N);

  if (!WIDTH_OK) begin : g_bad_width
    $error("bidir_log_shifter: N must be a power of two and at least 2");
  end

  for (genvar i = 0; i < K; i++) begin : g_stage
    logic [N-1:0] d_in;
    logic [N-1:0] d_out;

    if (i == 0) begin : g_first
      assign d_in = data_in;
    end else begin : g_next
      assign d_in = g_stage[i-1].d_out;
    end

    bls_stage #(
      .N    (N),
      .DIST (1 << i)
    ) u_stage (
      .d_in     (d_in),
      .stage_en (shamt[i]),
      .dir_left (dir_left),
      .d_out    (d_out)
    );
  end

  assign data_out = g_stage[K-1].d_out;

endmodule

// File: rtl/bidir_log_shifter_chk.sv
module bidir_log_shifter_chk #(
  parameter  int N = 8,
  localparam int K = (N > 1) ? $clog2(N) : 1
) (
  input logic [N-1:0] data_in,
  input logic [K-1:0] shamt,
  input logic         dir_left,
  input logic [N-1:0] data_out
);

  logic [N-1:0] low_mask;
  logic [N-1:0] high_mask;

  always_comb begin
    low_mask  = ~({N{1'b1}} << shamt);
    high_mask = ~({N{1'b1}} >> shamt);
  end

  always_comb begin
    if (shamt == '0)
      p_zero_amount_r1: assert (data_out == data_in);
    if (dir_left)
      p_low_fill_r2: assert ((data_out & low_mask) == '0);
    if (!dir_left)
      p_high_fill_r3: assert ((data_out & high_mask) == '0);
    p_no_new_ones_r5: assert ($countones(data_out) <= $countones(data_in));
    if ($onehot(data_in))
      p_single_bit_r6: assert ($onehot0(data_out));
  end

endmodule

bind bidir_log_shifter bidir_log_shifter_chk #(.N(N)) u_chk (
  .data_in  (data_in),
  .shamt    (shamt),
  .dir_left (dir_left),
  .data_out (data_out)
);

// File: tb/bidir_log_shifter_test.sv
module bidir_log_shifter_test;

  localparam int N = 8;
  localparam int K = 3;

  logic clk;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  logic [N-1:0] x;
  logic [K-1:0] a;
  logic         d;
  logic [N-1:0] y;

  logic [3:0] x4;
  logic [1:0] a4;
  logic       d4;
  logic [3:0] y4;

  bidir_log_shifter #(.N(N)) uut (
    .data_in (x), .shamt (a), .dir_left (d), .data_out (y)
  );

  bidir_log_shifter #(.N(4)) uut4 (
    .data_in (x4), .shamt (a4), .dir_left (d4), .data_out (y4)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s x=%h amt=%0d left=%0b actual=%h expected=%h", req, x, a, d, act, exp);
    end
  endtask

  task automatic apply(input int xv, input int av, input bit dv);
    @(negedge clk);
    x = N'(xv); a = K'(av); d = dv;
    #1;
  endtask

  initial begin
    x = '0; a = '0; d = 1'b0;
    x4 = '0; a4 = '0; d4 = 1'b0;
    #1;
    check("R1 idle", y, '0);

    // R1: zero amount passes the word in both directions
    apply(8'hC3, 0, 1'b1); check("R1 left", y, 8'hC3);
    apply(8'hC3, 0, 1'b0); check("R1 right", y, 8'hC3);

    // R2 / R3: full sweep against arithmetic
    for (int xv = 0; xv < 256; xv++) begin
      for (int av = 0; av < N; av++) begin
        apply(xv, av, 1'b1);
        check("R2 left sweep", y, N'((xv * (1 << av)) % 256));
        apply(xv, av, 1'b0);
        check("R3 right sweep", y, N'(xv / (1 << av)));
      end
    end

    // R4: extreme amount
    apply(8'hA5, N-1, 1'b1); check("R4 left max", y, 8'h80);
    apply(8'hA5, N-1, 1'b0); check("R4 right max", y, 8'h01);
    apply(8'h7E, N-1, 1'b1); check("R4 left max lsb0", y, 8'h00);
    apply(8'h7E, N-1, 1'b0); check("R4 right max msb0", y, 8'h00);

    // R5: popcount never grows
    for (int xv = 0; xv < 256; xv += 7) begin
      for (int av = 0; av < N; av++) begin
        apply(xv, av, av[0]);
        total++;
        if ($countones(y) > $countones(x)) begin
          bad++;
          $display("FAIL R5 x=%h amt=%0d actual=%0d ones expected<=%0d", x, a, $countones(y), $countones(x));
        end
      end
    end

    // R6: a single bit lands at p +/- amt or vanishes
    for (int p = 0; p < N; p++) begin
      for (int av = 0; av < N; av++) begin
        apply(1 << p, av, 1'b1);
        check("R6 onehot left", y, (p + av < N) ? N'(1 << (p + av)) : '0);
        apply(1 << p, av, 1'b0);
        check("R6 onehot right", y, (p - av >= 0) ? N'(1 << (p - av)) : '0);
      end
    end

    // R7: four-bit instance example and widths
    @(negedge clk);
    x4 = 4'b0010; a4 = 2'b10; d4 = 1'b1; #1;
    total++;
    if (y4 !== 4'b1000) begin bad++; $display("FAIL R7 left4 actual=%b expected=1000", y4); end
    d4 = 1'b0; #1;
    total++;
    if (y4 !== 4'b0000) begin bad++; $display("FAIL R7 right4 actual=%b expected=0000", y4); end
    total++;
    if ($bits(uut.shamt) != 3 || $bits(uut4.shamt) != 2) begin
      bad++;
      $display("FAIL R7 amount width actual=%0d/%0d expected=3/2", $bits(uut.shamt), $bits(uut4.shamt));
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule